// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block forms the word a parallel NOR flash returns on a read while the device is busy with an internal program or erase, and for a short time afterwards. A command decoder outside the block gives one pulse for each completed bus write cycle, along with the kind of operation being requested. The block counts these pulses. On the last write of a program sequence (4 writes) or an erase sequence (6 writes) it starts the operation. A down-counter then stands in for the operation's duration.

While the operation runs, reads return a polling bit at bit 7 and a toggling bit at bit 6. The polling bit is the complement of the stored bit for a program and a constant 0 for an erase. The toggling bit flips on each new read access. It is not driven by the clock. When the countdown ends there is a settling window. In this window bit 7 already shows its final value, bit 6 holds still and the other bits are not yet meaningful. After the window, reads return the stored word unchanged.

Top module: `flash_status_responder`

## Requirements
- R1: While `rst` is high at a clock edge, `busy` and `rd_data` are both 0 after that edge.
- R2: With `op_is_erase`=0, the 4th `wr_strobe` pulse counted while idle starts a program. `busy` is 1 after that edge and stays 0 after the 1st to 3rd pulses.
- R3: With `op_is_erase`=1, the 6th counted `wr_strobe` pulse starts an erase. `busy` stays 0 after the 1st to 5th pulses.
- R4: A `seq_clear` pulse sets the write count back to zero, so a full new sequence is needed before an operation starts.
- R5: `wr_strobe` pulses while `busy` is 1 are not counted.
- R6: `busy` stays 1 for exactly PROG_CYC clock cycles after a program starts and ERASE_CYC cycles after an erase starts. A settling window of SETTLE_CYC cycles follows.
- R7: While a program is busy, bit 7 of the returned word is the inverse of bit 7 of `array_data`.
- R8: While an erase is busy, bit 7 of the returned word is 0.
- R9: Bit 6 is 0 at the start of each operation. While busy, it inverts each time the read enable (`ce_n` and `oe_n` both low) goes active. Bits other than 7 and 6 read 0 while busy and while settling.
- R10: In the settling window, bit 7 equals `array_data` bit 7 after a program and 1 after an erase. Bit 6 keeps its last value.
- R11: When neither busy nor settling, the returned word equals `array_data`.
- R12: `rd_data` is registered. It reflects the state and the `array_data` value present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | One-cycle pulse for each completed command bus write |
| op_is_erase | input | 1 | 1 = the sequence in progress is an erase, 0 = a program |
| seq_clear | input | 1 | Aborts a partial command sequence |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| array_data | input | DW | True word stored at the addressed location |
| rd_data | output | DW | Word returned on the data bus |
| busy | output | 1 | Internal operation in progress |

## Verification
The bench builds the block with PROG_CYC=5, ERASE_CYC=9 and SETTLE_CYC=3 at a 16-bit word. With these short durations, every cycle of each operation can be compared against an arithmetic model. That covers the whole busy period, the settling window and the return to true data.

The read enable is pulsed on alternate cycles, through `ce_n` in one run and `oe_n` in another. The array word changes on every cycle. Together these reach every toggle step and both polarities of the polling bit. Separate strobe sequences cover the write-count boundaries, abort and the masking of strobes during busy.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  // Bit positions read by host polling software; fixed by behaviour.
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/fsr_seq_count.sv
module fsr_seq_count #(
  parameter int PROG_WRITES  = 4,
  parameter int ERASE_WRITES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_strobe,
  input  logic op_is_erase,
  input  logic seq_clear,
  input  logic busy,
  output logic launch,
  output logic launch_erase
);
  localparam int MAXW = (PROG_WRITES > ERASE_WRITES) ? PROG_WRITES : ERASE_WRITES;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] count_q;
  logic [CW-1:0] need;
  logic          take;
  logic          hit;

  assign need = op_is_erase ? CW'(ERASE_WRITES) : CW'(PROG_WRITES);
  assign take = wr_strobe && !busy && !seq_clear;
  assign hit  = take && ((count_q + CW'(1)) == need);

  assign launch       = hit;
  assign launch_erase = op_is_erase;

  always_ff @(posedge clk) begin
    if (rst || seq_clear) begin
      count_q <= '0;
    end else if (take) begin
      count_q <= hit ? '0 : count_q + CW'(1);
    end
  end
endmodule

// File: rtl/fsr_op_timer.sv
module fsr_op_timer
  import flash_stat_pkg::*;
#(
  parameter int PROG_CYC   = 64,
  parameter int ERASE_CYC  = 256,
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic launch_erase,
  output logic busy,
  output logic settle,
  output logic op_erase
);
  localparam int MAXD = max3(PROG_CYC, ERASE_CYC, SETTLE_CYC);
  localparam int TW   = $clog2(MAXD + 1);
  localparam logic [TW-1:0] PROG_LD   = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] ERASE_LD  = TW'(ERASE_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);

  phase_e        phase_q;
  logic [TW-1:0] cnt_q;
  logic          erase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      erase_q <= 1'b0;
    end else if (launch) begin
      phase_q <= PH_BUSY;
      erase_q <= launch_erase;
      cnt_q   <= launch_erase ? ERASE_LD : PROG_LD;
    end else begin
      case (phase_q)
        PH_BUSY: begin
          if (cnt_q == '0) begin
            phase_q <= PH_SETTLE;
            cnt_q   <= SETTLE_LD;
          end else begin
            cnt_q <= cnt_q - TW'(1);
          end
        end
        PH_SETTLE: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q - TW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (phase_q == PH_BUSY);
  assign settle   = (phase_q == PH_SETTLE);
  assign op_erase = erase_q;
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic busy,
  input  logic launch,
  output logic tog,
  output logic rd_rise
);
  logic rd_act;
  logic act_q;
  logic tog_q;

  assign rd_act  = !ce_n && !oe_n;
  assign rd_rise = rd_act && !act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      act_q <= rd_act;
      if (launch) begin
        tog_q <= 1'b0;
      end else if (busy && rd_rise) begin
        tog_q <= !tog_q;
      end
    end
  end

  assign tog = tog_q;
endmodule

// File: rtl/fsr_word_mux.sv
module fsr_word_mux
  import flash_stat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          settle,
  input  logic          op_erase,
  input  logic          tog,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] word_d;
  logic [DW-1:0] word_q;

  always_comb begin
    word_d = array_data;
    if (busy) begin
      word_d           = '0;
      word_d[POLL_BIT] = op_erase ? 1'b0 : !array_data[POLL_BIT];
      word_d[TOG_BIT]  = tog;
    end else if (settle) begin
      word_d           = '0;
      word_d[POLL_BIT] = op_erase ? 1'b1 : array_data[POLL_BIT];
      word_d[TOG_BIT]  = tog;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_d;
  end

  assign rd_data = word_q;
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
  import flash_stat_pkg::*;
#(
  parameter int DW           = 16,
  parameter int PROG_WRITES  = 4,
  parameter int ERASE_WRITES = 6,
  parameter int PROG_CYC     = 64,
  parameter int ERASE_CYC    = 256,
  parameter int SETTLE_CYC   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_strobe,
  input  logic          op_is_erase,
  input  logic          seq_clear,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  logic launch_w;
  logic launch_erase_w;
  logic busy_w;
  logic settle_w;
  logic op_erase_w;
  logic tog_w;
  logic rd_rise_w;

  fsr_seq_count #(
    .PROG_WRITES (PROG_WRITES),
    .ERASE_WRITES(ERASE_WRITES)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .wr_strobe   (wr_strobe),
    .op_is_erase (op_is_erase),
    .seq_clear   (seq_clear),
    .busy        (busy_w),
    .launch      (launch_w),
    .launch_erase(launch_erase_w)
  );

  fsr_op_timer #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .launch      (launch_w),
    .launch_erase(launch_erase_w),
    .busy        (busy_w),
    .settle      (settle_w),
    .op_erase    (op_erase_w)
  );

  fsr_toggle u_tog (
    .clk    (clk),
    .rst    (rst),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .busy   (busy_w),
    .launch (launch_w),
    .tog    (tog_w),
    .rd_rise(rd_rise_w)
  );

  fsr_word_mux #(
    .DW(DW)
  ) u_mux (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy_w),
    .settle    (settle_w),
    .op_erase  (op_erase_w),
    .tog       (tog_w),
    .array_data(array_data),
    .rd_data   (rd_data)
  );

  assign busy = busy_w;
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk
  import flash_stat_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_strobe,
  input logic          launch,
  input logic          busy,
  input logic          settle,
  input logic          op_erase,
  input logic          rd_rise,
  input logic [DW-1:0] array_data,
  input logic [DW-1:0] rd_data
);
  // R2
  launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy);

  // R5
  strobe_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_strobe) |-> !launch);

  // R7
  prog_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy) && !$past(op_erase))
      |-> (rd_data[POLL_BIT] == !$past(array_data[POLL_BIT])));

  // R8
  erase_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy) && $past(op_erase)) |-> (rd_data[POLL_BIT] == 1'b0));

  // R9
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(busy, 2) && $past(busy) &&
     $past(rd_rise, 2) && !$past(launch, 2))
      |-> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

  // R10
  settle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(settle, 2) && $past(settle))
      |-> $stable(rd_data[TOG_BIT]));

  // R11
  idle_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy) && !$past(settle)) |-> (rd_data == $past(array_data)));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && settle));
endmodule

bind flash_status_responder fsr_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_strobe (wr_strobe),
  .launch    (launch_w),
  .busy      (busy_w),
  .settle    (settle_w),
  .op_erase  (op_erase_w),
  .rd_rise   (rd_rise_w),
  .array_data(array_data),
  .rd_data   (rd_data)
);

// File: tb/tb_flash_status_responder.sv
module tb_flash_status_responder;
  localparam int DW  = 16;
  localparam int PC  = 5;
  localparam int EC  = 9;
  localparam int SC  = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_strobe, op_is_erase, seq_clear, ce_n, oe_n;
  logic [DW-1:0] array_data;
  logic [DW-1:0] rd_data;
  logic          busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = !clk;

  flash_status_responder #(
    .DW(DW), .PROG_WRITES(4), .ERASE_WRITES(6),
    .PROG_CYC(PC), .ERASE_CYC(EC), .SETTLE_CYC(SC)
  ) dut (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .op_is_erase(op_is_erase),
    .seq_clear(seq_clear), .ce_n(ce_n), .oe_n(oe_n),
    .array_data(array_data), .rd_data(rd_data), .busy(busy)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  task automatic strobe_once();
    wr_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Issue a full sequence; busy must stay low until the last write.
  task automatic launch_op(input bit erase, input string req);
    int need;
    need = erase ? 6 : 4;
    op_is_erase = erase;
    for (int i = 1; i <= need; i++) begin
      strobe_once();
      check_eq(req, busy, (i == need) ? 1 : 0);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input int p, input bit erase,
                                             input logic [DW-1:0] d, input bit t);
    logic [DW-1:0] w;
    int dur;
    dur = erase ? EC : PC;
    if (p < dur) begin
      w = '0; w[7] = erase ? 1'b0 : !d[7]; w[6] = t;
    end else if (p < dur + SC) begin
      w = '0; w[7] = erase ? 1'b1 : d[7]; w[6] = t;
    end else begin
      w = d;
    end
    return w;
  endfunction

  // Run one operation cycle by cycle; reads on odd cycles via ce_n or oe_n.
  task automatic run_op(input bit erase, input logic [DW-1:0] base, input bit use_oe);
    int dur;
    bit tog_e, prev_re, re_now, busy_pre;
    logic [DW-1:0] d, ew;
    string req;
    dur = erase ? EC : PC;
    ce_n = 1'b1; oe_n = 1'b1;
    launch_op(erase, erase ? "R3" : "R2");
    tog_e = 1'b0;
    prev_re = 1'b0;
    for (int k = 1; k <= dur + SC + 3; k++) begin
      re_now = (k % 2) == 1;
      if (use_oe) begin ce_n = 1'b0; oe_n = !re_now; end
      else        begin oe_n = 1'b0; ce_n = !re_now; end
      d = base ^ DW'(k * 16'h1357);
      array_data = d;
      @(posedge clk);
      @(negedge clk);
      busy_pre = (k - 1) < dur;
      ew = exp_word(k - 1, erase, d, tog_e);
      if (busy_pre) req = erase ? "R8 R9" : "R7 R9";
      else if ((k - 1) < dur + SC) req = "R10";
      else req = "R11";
      check_eq(req, rd_data, ew);
      check_eq("R6", busy, (k < dur) ? 1 : 0);
      if (busy_pre && re_now && !prev_re) tog_e = !tog_e;
      prev_re = re_now;
    end
    ce_n = 1'b1; oe_n = 1'b1;
    idle_cycles(2);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; wr_strobe = 1'b0; op_is_erase = 1'b0; seq_clear = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; array_data = 16'hA5C3;
    idle_cycles(3);
    check_eq("R1", rd_data, 16'h0000);
    check_eq("R1", busy, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_eq("R12", rd_data, 16'hA5C3);
    array_data = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    check_eq("R11", rd_data, 16'h1234);

    run_op(1'b0, 16'h0080, 1'b0);
    run_op(1'b0, 16'h7F3C, 1'b1);
    run_op(1'b1, 16'hFFFF, 1'b1);
    run_op(1'b1, 16'h5A5A, 1'b0);

    // R4: abort after two writes, then a full fresh program sequence is needed
    op_is_erase = 1'b0;
    strobe_once();
    strobe_once();
    seq_clear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    seq_clear = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      strobe_once();
      check_eq("R4", busy, (i == 4) ? 1 : 0);
    end
    // R5: writes during busy must not count toward the next sequence
    strobe_once();
    strobe_once();
    idle_cycles(PC + SC + 4);
    check_eq("R5", busy, 0);
    for (int i = 1; i <= 4; i++) begin
      strobe_once();
      check_eq("R5", busy, (i == 4) ? 1 : 0);
    end
    idle_cycles(PC + SC + 4);
    check_eq("R6", busy, 0);

    summary();
    $finish;
  end
endmodule